// File: doc/BRIEF.md
# Host Packet FIFO Access Port

This block is the host-facing window onto two quadlet (32-bit) FIFOs. The transmit side is loaded by two write-only addresses. Every word of an outgoing packet except the last goes through the "continue" address. The last word goes through the "final" address, and that write is what marks the packet boundary and commits the packet. A small transmitter stub then drains the committed packet one quadlet per cycle. It raises a launch pulse at the start and a done pulse at the end.

The receive side is filled by the link through a valid/data push interface. The host drains it through a read-only address: each read pops the next quadlet into a data register. When the receive FIFO is empty, a read leaves the register holding the last quadlet delivered rather than returning junk. A clear request empties the transmit side and drops out again on its own. A bus-reset event zeroes the read register and empties both FIFOs.

A final write that arrives while a packet is still draining is parked in a single pending slot. It is launched only after the running packet has signalled done.

Top module: `pkt_host_port`

## Requirements
- R1: A write with `host_wr_last`=0 (continue address) pushes one quadlet into the transmit FIFO and produces no launch pulse and no output word.
- R2: A write with `host_wr_last`=1 (final address) pushes the last quadlet and commits the packet. A one-cycle `tx_launch` follows, then exactly the packet's quadlets on `tx_out_data` in write order, one per cycle with `tx_out_valid` high. `tx_done` pulses for one cycle in the cycle after the last word.
- R3: The transmit FIFO holds 16 quadlets, and `tx_full` is high at 16. A write while full is dropped and sets `tx_ovf`. `tx_ovf` stays set until reset or bus reset.
- R4: A launch never occurs while a packet is draining. A final write made during a drain is held pending and launched after that packet's `tx_done`, with its words following the earlier packet's.
- R5: Each host read of a non-empty receive FIFO presents the next quadlet, in push order, on `host_rd_data` from the cycle after the read.
- R6: A host read while the receive FIFO is empty leaves `host_rd_data` at the last quadlet delivered.
- R7: The receive FIFO holds 16 quadlets. A push while it is full is dropped.
- R8: A clear request raises `tx_clr_pend` for one cycle. The transmit FIFO is then empty, any open or pending packet is discarded, and `tx_clr_pend` is back at 0.
- R9: After reset or a `bus_rst` pulse, `host_rd_data` is 0x00000000, both FIFOs are empty, `tx_ovf` is 0 and no launch is issued.
- R10: When a receive push and a host read fall in the same cycle, the read is judged on the occupancy before that cycle. An empty FIFO keeps the old read value, and the pushed word is returned by the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rst | input | 1 | Bus-reset event, one-cycle pulse |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_last | input | 1 | 0: continue address, 1: final (commit) address |
| host_wr_data | input | 32 | Host write quadlet |
| host_rd_en | input | 1 | Host read strobe on the receive-data address |
| host_rd_data | output | 32 | Receive-data register |
| tx_clr_req | input | 1 | Request to empty the transmit side |
| tx_clr_pend | output | 1 | Clear request bit, self-clearing |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_ovf | output | 1 | Sticky transmit overflow |
| tx_launch | output | 1 | Transmit start pulse |
| tx_busy | output | 1 | Stub is draining a packet |
| tx_done | output | 1 | Packet fully consumed pulse |
| tx_out_valid | output | 1 | Stub output word valid |
| tx_out_data | output | 32 | Stub output word |
| rx_push_valid | input | 1 | Receive push strobe |
| rx_push_data | input | 32 | Receive push quadlet |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |

## Verification
A link-side receive push and a host read can land in the same cycle. The bench provokes this with the receive FIFO empty, and again holding a single entry. In the empty case it checks that the read value is held and the pushed word comes out on the next read. In the one-entry case it checks that the old head is returned and the new word follows. Transmit writes also coincide with the stub popping words during a drain. Back-to-back packets exercise this, and the bench judges it by the complete, ordered output stream and by launch never preceding the previous done.

// File: rtl/pkt_host_pkg.sv
package pkt_host_pkg;
    localparam int unsigned QUAD_W = 32;
    typedef logic [QUAD_W-1:0] quad_t;
    typedef enum logic {
        WR_CONT = 1'b0,
        WR_LAST = 1'b1
    } wr_kind_e;
endpackage

// File: rtl/pkt_qfifo.sv
module pkt_qfifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t     st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic         do_push, do_pop;

    assign full    = (st_q.cnt == CW'(DEPTH));
    assign empty   = (st_q.cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[st_q.rp];

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) begin
                st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + AW'(1);
            end
            if (do_pop) begin
                st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + AW'(1);
            end
            case ({do_push, do_pop})
                2'b10:   st_d.cnt = st_q.cnt + CW'(1);
                2'b01:   st_d.cnt = st_q.cnt - CW'(1);
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= push_data;
    end
endmodule

// File: rtl/pkt_tx_sched.sv
module pkt_tx_sched
    import pkt_host_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flush,
    input  logic     bus_rst,
    input  logic     wr_en,
    input  wr_kind_e wr_kind,
    input  logic     fifo_full,
    output logic     fifo_push,
    output logic     fifo_pop,
    output logic     ovf,
    output logic     launch,
    output logic     busy,
    output logic     done
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] open_len;
        logic          pend;
        logic [CW-1:0] pend_len;
        logic          busy;
        logic [CW-1:0] rem;
        logic          launch;
        logic          done;
        logic          ovf;
    } sched_st_t;

    sched_st_t st_d, st_q;
    logic      start, last_blocked, accept;

    assign start        = st_q.pend && !st_q.busy;
    assign last_blocked = st_q.pend && !start;
    assign accept       = wr_en && !flush && !fifo_full
                          && !((wr_kind == WR_LAST) && last_blocked);
    assign fifo_push    = accept;
    assign fifo_pop     = st_q.busy && (st_q.rem != '0);

    always_comb begin
        st_d        = st_q;
        st_d.launch = 1'b0;
        st_d.done   = 1'b0;

        if (wr_en && !flush && !accept) st_d.ovf = 1'b1;

        if (fifo_pop) begin
            st_d.rem = st_q.rem - CW'(1);
            if (st_q.rem == CW'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end

        if (start) begin
            st_d.pend   = 1'b0;
            st_d.busy   = 1'b1;
            st_d.rem    = st_q.pend_len;
            st_d.launch = 1'b1;
        end

        if (accept) begin
            if (wr_kind == WR_CONT) begin
                st_d.open_len = st_q.open_len + CW'(1);
            end else begin
                st_d.pend     = 1'b1;
                st_d.pend_len = st_q.open_len + CW'(1);
                st_d.open_len = '0;
            end
        end

        if (flush) begin
            st_d.open_len = '0;
            st_d.pend     = 1'b0;
            st_d.pend_len = '0;
            st_d.busy     = 1'b0;
            st_d.rem      = '0;
            st_d.launch   = 1'b0;
            st_d.done     = 1'b0;
        end
        if (bus_rst) st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ovf    = st_q.ovf;
    assign launch = st_q.launch;
    assign busy   = st_q.busy;
    assign done   = st_q.done;
endmodule

// File: rtl/pkt_host_port.sv
module pkt_host_port
    import pkt_host_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rst,
    input  logic        host_wr_en,
    input  logic        host_wr_last,
    input  logic [31:0] host_wr_data,
    input  logic        host_rd_en,
    output logic [31:0] host_rd_data,
    input  logic        tx_clr_req,
    output logic        tx_clr_pend,
    output logic        tx_full,
    output logic        tx_empty,
    output logic        tx_ovf,
    output logic        tx_launch,
    output logic        tx_busy,
    output logic        tx_done,
    output logic        tx_out_valid,
    output logic [31:0] tx_out_data,
    input  logic        rx_push_valid,
    input  logic [31:0] rx_push_data,
    output logic        rx_full,
    output logic        rx_empty
);
    typedef struct packed {
        logic  clr;
        quad_t rd;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     tx_flush, tx_push, tx_pop, rx_pop;
    quad_t    rx_head, tx_head;

    assign tx_flush = st_q.clr || bus_rst;
    assign rx_pop   = host_rd_en && !rx_empty && !bus_rst;

    always_comb begin
        st_d     = st_q;
        st_d.clr = tx_clr_req && !bus_rst;
        if (bus_rst)     st_d.rd = '0;
        else if (rx_pop) st_d.rd = rx_head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pkt_tx_sched #(.DEPTH(DEPTH)) sched_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .bus_rst   (bus_rst),
        .wr_en     (host_wr_en),
        .wr_kind   (wr_kind_e'(host_wr_last)),
        .fifo_full (tx_full),
        .fifo_push (tx_push),
        .fifo_pop  (tx_pop),
        .ovf       (tx_ovf),
        .launch    (tx_launch),
        .busy      (tx_busy),
        .done      (tx_done)
    );

    pkt_qfifo #(.W(QUAD_W), .DEPTH(DEPTH)) txq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (tx_flush),
        .push      (tx_push),
        .push_data (host_wr_data),
        .pop       (tx_pop),
        .head      (tx_head),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    pkt_qfifo #(.W(QUAD_W), .DEPTH(DEPTH)) rxq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (bus_rst),
        .push      (rx_push_valid),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .head      (rx_head),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    assign host_rd_data = st_q.rd;
    assign tx_clr_pend  = st_q.clr;
    assign tx_out_valid = tx_pop;
    assign tx_out_data  = tx_head;
endmodule

// File: rtl/pkt_host_port_chk.sv
module pkt_host_port_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_rst,
    input logic        host_wr_en,
    input logic        host_rd_en,
    input logic [31:0] host_rd_data,
    input logic        tx_clr_req,
    input logic        tx_clr_pend,
    input logic        tx_full,
    input logic        tx_empty,
    input logic        tx_ovf,
    input logic        tx_launch,
    input logic        tx_busy,
    input logic        tx_done,
    input logic        tx_out_valid,
    input logic        rx_empty
);
    AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_launch |-> $past(!tx_busy)); // R4
    AST_DONE_ENDS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> ($past(tx_out_valid) && !tx_out_valid)); // R2
    AST_FULL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full && host_wr_en && !bus_rst && !tx_clr_pend) |=> tx_ovf); // R3
    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && rx_empty && !bus_rst) |=> $stable(host_rd_data)); // R6
    AST_CLEAR_SELF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_clr_pend && !tx_clr_req && !bus_rst) |=> (!tx_clr_pend && tx_empty)); // R8
    AST_BUS_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (host_rd_data == 32'h0 && rx_empty && tx_empty && !tx_ovf && !tx_launch)); // R9
endmodule

bind pkt_host_port pkt_host_port_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_rst      (bus_rst),
    .host_wr_en   (host_wr_en),
    .host_rd_en   (host_rd_en),
    .host_rd_data (host_rd_data),
    .tx_clr_req   (tx_clr_req),
    .tx_clr_pend  (tx_clr_pend),
    .tx_full      (tx_full),
    .tx_empty     (tx_empty),
    .tx_ovf       (tx_ovf),
    .tx_launch    (tx_launch),
    .tx_busy      (tx_busy),
    .tx_done      (tx_done),
    .tx_out_valid (tx_out_valid),
    .rx_empty     (rx_empty)
);

// File: tb/pkt_host_port_tb_top.sv
`timescale 1ns/1ps
module pkt_host_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rst = 1'b0;
    logic        host_wr_en = 1'b0;
    logic        host_wr_last = 1'b0;
    logic [31:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0;
    logic [31:0] host_rd_data;
    logic        tx_clr_req = 1'b0;
    logic        tx_clr_pend, tx_full, tx_empty, tx_ovf;
    logic        tx_launch, tx_busy, tx_done, tx_out_valid;
    logic [31:0] tx_out_data;
    logic        rx_push_valid = 1'b0;
    logic [31:0] rx_push_data = '0;
    logic        rx_full, rx_empty;

    int total = 0;
    int bad   = 0;

    // monitor state, written only by the monitor
    logic [31:0] obs [0:255];
    int obs_n = 0, launch_n = 0, done_n = 0, early_n = 0;
    int cyc = 0, last_valid_cyc = -1, done_cyc = -1;

    always #10 clk = ~clk;

    pkt_host_port dut_i (.*);

    always @(posedge clk) begin
        #2;
        cyc = cyc + 1;
        if (tx_out_valid) begin
            obs[obs_n[7:0]] = tx_out_data;
            obs_n = obs_n + 1;
            last_valid_cyc = cyc;
        end
        if (tx_launch) begin
            if (launch_n != done_n) early_n = early_n + 1;
            launch_n = launch_n + 1;
        end
        if (tx_done) begin
            done_n = done_n + 1;
            done_cyc = cyc;
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic last, input logic [31:0] d);
        host_wr_en = 1'b1; host_wr_last = last; host_wr_data = d;
        tick();
        host_wr_en = 1'b0; host_wr_last = 1'b0;
    endtask

    task automatic rxp(input logic [31:0] d);
        rx_push_valid = 1'b1; rx_push_data = d;
        tick();
        rx_push_valid = 1'b0;
    endtask

    task automatic hr();
        host_rd_en = 1'b1;
        tick();
        host_rd_en = 1'b0;
    endtask

    task automatic brst();
        bus_rst = 1'b1;
        tick();
        bus_rst = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 reset rd_data", host_rd_data, 32'h0);
        chk("R9 reset rx_empty", {31'b0, rx_empty}, 32'd1);
        chk("R9 reset tx_empty", {31'b0, tx_empty}, 32'd1);
        chk("R9 reset tx_full", {31'b0, tx_full}, 32'd0);
        chk("R9 reset ovf", {31'b0, tx_ovf}, 32'd0);
        chk("R9 reset launches", launch_n, 0);
    endtask

    task automatic t_packet();
        int base = obs_n;
        int l0 = launch_n;
        for (int i = 0; i < 3; i++) hw(1'b0, 32'hA000_0000 + i);
        tick(4);
        chk("R1 no launch on continue", launch_n - l0, 0);
        chk("R1 no output on continue", obs_n - base, 0);
        chk("R1 words stored", {31'b0, tx_empty}, 32'd0);
        hw(1'b1, 32'hA000_0003);
        tick(10);
        chk("R2 one launch", launch_n - l0, 1);
        chk("R2 word count", obs_n - base, 4);
        for (int i = 0; i < 4; i++)
            chk("R2 word order", obs[(base + i) % 256], 32'hA000_0000 + i);
        chk("R2 done after last word", done_cyc, last_valid_cyc + 1);
        chk("R2 fifo drained", {31'b0, tx_empty}, 32'd1);
    endtask

    task automatic t_pending();
        int base = obs_n;
        int l0 = launch_n;
        int d0 = done_n;
        for (int i = 0; i < 3; i++) hw(1'b0, 32'hB000_0000 + i);
        hw(1'b1, 32'hB000_0003);
        hw(1'b0, 32'hC000_0000);
        hw(1'b1, 32'hC000_0001);
        tick(20);
        chk("R4 two launches", launch_n - l0, 2);
        chk("R4 two dones", done_n - d0, 2);
        chk("R4 no launch before done", early_n, 0);
        chk("R4 word count", obs_n - base, 6);
        for (int i = 0; i < 4; i++)
            chk("R4 first packet order", obs[(base + i) % 256], 32'hB000_0000 + i);
        for (int i = 0; i < 2; i++)
            chk("R4 second packet order", obs[(base + 4 + i) % 256], 32'hC000_0000 + i);
    endtask

    task automatic t_full_clear();
        int base;
        for (int i = 0; i < 16; i++) hw(1'b0, 32'hD000_0000 + i);
        chk("R3 full at 16", {31'b0, tx_full}, 32'd1);
        chk("R3 no ovf yet", {31'b0, tx_ovf}, 32'd0);
        hw(1'b0, 32'hDEAD_0000);
        chk("R3 ovf set", {31'b0, tx_ovf}, 32'd1);
        chk("R3 still full", {31'b0, tx_full}, 32'd1);
        tx_clr_req = 1'b1;
        tick();
        tx_clr_req = 1'b0;
        chk("R8 clear bit raised", {31'b0, tx_clr_pend}, 32'd1);
        tick();
        chk("R8 clear bit dropped", {31'b0, tx_clr_pend}, 32'd0);
        chk("R8 fifo emptied", {31'b0, tx_empty}, 32'd1);
        chk("R3 ovf sticky", {31'b0, tx_ovf}, 32'd1);
        base = obs_n;
        hw(1'b1, 32'h5555_0001);
        tick(6);
        chk("R8 open words discarded", obs_n - base, 1);
        chk("R8 next packet word", obs[base % 256], 32'h5555_0001);
        brst();
        chk("R9 bus reset clears ovf", {31'b0, tx_ovf}, 32'd0);
    endtask

    task automatic t_rx();
        for (int i = 0; i < 3; i++) rxp(32'hE000_0010 + i);
        for (int i = 0; i < 3; i++) begin
            hr();
            chk("R5 read order", host_rd_data, 32'hE000_0010 + i);
        end
        chk("R5 rx empty", {31'b0, rx_empty}, 32'd1);
        hr();
        chk("R6 empty read holds", host_rd_data, 32'hE000_0012);
        hr();
        chk("R6 empty read holds again", host_rd_data, 32'hE000_0012);
    endtask

    task automatic t_rx_full();
        for (int i = 0; i < 17; i++) rxp(32'hF000_0000 + i);
        chk("R7 rx full", {31'b0, rx_full}, 32'd1);
        for (int i = 0; i < 16; i++) begin
            hr();
            chk("R7 kept words", host_rd_data, 32'hF000_0000 + i);
        end
        hr();
        chk("R7 extra push dropped", host_rd_data, 32'hF000_000F);
    endtask

    task automatic t_rx_same();
        logic [31:0] prev = host_rd_data;
        rx_push_valid = 1'b1; rx_push_data = 32'h1234_0001; host_rd_en = 1'b1;
        tick();
        rx_push_valid = 1'b0; host_rd_en = 1'b0;
        chk("R10 empty read with push holds", host_rd_data, prev);
        hr();
        chk("R10 pushed word next", host_rd_data, 32'h1234_0001);
        rxp(32'h1234_0002);
        rx_push_valid = 1'b1; rx_push_data = 32'h1234_0003; host_rd_en = 1'b1;
        tick();
        rx_push_valid = 1'b0; host_rd_en = 1'b0;
        chk("R10 one entry read with push", host_rd_data, 32'h1234_0002);
        hr();
        chk("R10 new word follows", host_rd_data, 32'h1234_0003);
        hr();
        chk("R10 then empty holds", host_rd_data, 32'h1234_0003);
    endtask

    task automatic t_busrst();
        int l0 = launch_n;
        rxp(32'h7777_0001);
        rxp(32'h7777_0002);
        hr();
        hw(1'b0, 32'h8888_0000);
        hw(1'b0, 32'h8888_0001);
        chk("R9 setup rd_data", host_rd_data, 32'h7777_0001);
        brst();
        chk("R9 bus reset rd_data", host_rd_data, 32'h0);
        chk("R9 bus reset rx_empty", {31'b0, rx_empty}, 32'd1);
        chk("R9 bus reset tx_empty", {31'b0, tx_empty}, 32'd1);
        hr();
        chk("R9 read after bus reset", host_rd_data, 32'h0);
        tick(3);
        chk("R9 no launch", launch_n - l0, 0);
    endtask

    initial begin
        logic timed_out = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick();
        fork
            begin
                t_reset();
                t_packet();
                t_pending();
                t_full_clear();
                t_rx();
                t_rx_full();
                t_rx_same();
                t_busrst();
            end
            begin
                tick(50000);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule